// File: doc/BRIEF.md
# Reed-Solomon Symbol Error Applier

This block sits after a Reed-Solomon decoder that works on 12-bit symbols. The decoder finds up to four symbol errors in a flash page. Each error is a symbol position plus a 12-bit error pattern. The block turns each position into one or two byte addresses and a byte-wide XOR mask. It then corrects those bytes by read-modify-write through a single-port byte buffer. The buffer holds 2048 data bytes, and the spare area follows it directly at flat address 2048.

Two consecutive 12-bit symbols pack into three bytes. An odd position starts on a byte boundary and spills its low nibble into the upper half of the next byte. An even position starts in the lower nibble of the byte before. Position 1365 is the one symbol that straddles the data/spare boundary. Its high byte lands in data byte 2047 and its low nibble lands in spare byte 0.

Before any byte is touched, the whole error list is checked. If any listed error cannot be applied, the page is counted as failed and the buffer is left alone. A successful page adds its error count to a running corrected-symbol counter.

Top module: `rs_symfix`

## Requirements
- R1: When `ecc_flag` is low at the start edge, the block makes no buffer access and leaves both counters unchanged. It still gives the `done` pulse, whatever positions are presented.
- R2: Any applied entry with a position above 1374 makes the page uncorrectable. Then `fail_count` increments by one, `corr_count` holds, and no buffer access occurs.
- R3: Position 0 touches only byte 0, with the mask equal to pattern bits 7:0. A pattern above 0xFF at position 0 makes the page uncorrectable, with the same effect as R2.
- R4: An odd position p, with t = floor(3p/2), XORs byte t with pattern bits 11:4. It XORs byte t+1 with pattern bits 3:0 placed in the upper nibble.
- R5: An even nonzero position p, with t = 3p/2, XORs byte t-1 with pattern bits 11:8 in the lower nibble. It XORs byte t with pattern bits 7:0.
- R6: Position 1365 XORs flat byte 2047 (last data byte) with pattern bits 11:4. It XORs flat byte 2048 (spare byte 0) with pattern bits 3:0 in the upper nibble.
- R7: Positions 1366 to 1374 follow R4/R5. Spare byte k sits at flat address 2048+k, so the spare index is the computed byte index minus 2048. No access ever addresses beyond the 2112-byte buffer.
- R8: Only the first `err_n` entries are used, and an `err_n` above 4 is treated as 4. Unused slots are ignored even if they hold out-of-range positions.
- R9: Each byte is read in one cycle and written in the very next cycle, at the same address, with `mem_rdata ^ mask`. The buffer has one-cycle read latency. Bytes of a symbol go in ascending address order, and symbols go in slot order 0..3.
- R10: Let start be sampled at edge 0, and let B be the number of bytes written (0 if skipped or rejected). Then `done` is high for exactly one cycle after edge 1+2B, and the counters update at that same edge. `busy` is high from edge 0 until that edge. On success `corr_count` grows by the number of applied entries.
- R11: A `start` asserted while `busy` is high is ignored. The inputs are captured only at an accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin processing one page's error list |
| ecc_flag | input | 1 | Decoder reports errors present; correction gated by it |
| err_n | input | 3 | Number of valid entries (0..4, larger clamped to 4) |
| err_pos | input | 48 | Four 12-bit symbol positions, slot i at bits 12i+11:12i |
| err_pat | input | 48 | Four 12-bit error patterns, slot i at bits 12i+11:12i |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_en | output | 1 | Buffer access enable |
| mem_we | output | 1 | Buffer write (1) or read (0) |
| mem_addr | output | 12 | Flat byte address (spare at 2048+) |
| mem_wdata | output | 8 | Corrected byte |
| mem_rdata | input | 8 | Read data, valid the cycle after a read |
| corr_count | output | 16 | Total symbols corrected |
| fail_count | output | 16 | Total uncorrectable pages |

## Verification
After the start edge, the first cycle is the list check, with no access and `busy` high. Cycles 1 through 2B after the start edge must each show the predicted read or write, and each write must carry the predicted corrected byte. `done` and the counters are due one cycle after that, and `done` must be low again one cycle later. The bench derives the access list and B from the requirements alone. It samples on every falling edge of each of those cycles, so each result is compared in exactly the cycle it is due. After each page, the whole buffer is compared against a behavioural copy with the corrections applied in order.

// File: rtl/rs_symfix.sv
module rs_symfix #(
  parameter int DATA_BYTES  = 2048,
  parameter int SPARE_BYTES = 64,
  parameter int MAX_ERR     = 4,
  parameter int MAX_POS     = 1374,
  parameter int PW          = 12,
  parameter int SYM_W       = 12,
  parameter int CNT_W       = 16,
  parameter int AW          = $clog2(DATA_BYTES + SPARE_BYTES),
  parameter int NW          = $clog2(MAX_ERR + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     ecc_flag,
  input  logic [NW-1:0]            err_n,
  input  logic [MAX_ERR*PW-1:0]    err_pos,
  input  logic [MAX_ERR*SYM_W-1:0] err_pat,
  output logic                     busy,
  output logic                     done,
  output logic                     mem_en,
  output logic                     mem_we,
  output logic [AW-1:0]            mem_addr,
  output logic [7:0]               mem_wdata,
  input  logic [7:0]               mem_rdata,
  output logic [CNT_W-1:0]         corr_count,
  output logic [CNT_W-1:0]         fail_count
);

  localparam int IW = (MAX_ERR > 1) ? $clog2(MAX_ERR) : 1;

  typedef enum logic [1:0] {S_IDLE, S_CHK, S_RD, S_WR} st_t;

  st_t               st;
  logic              gate_r, half, done_q;
  logic [NW-1:0]     n_r;
  logic [IW-1:0]     idx;
  logic [PW-1:0]     pos_r [MAX_ERR];
  logic [SYM_W-1:0]  pat_r [MAX_ERR];
  logic [CNT_W-1:0]  corr_q, fail_q;
  logic [MAX_ERR-1:0] bad_v;

  for (genvar g = 0; g < MAX_ERR; g++) begin : g_chk
    assign bad_v[g] = (n_r > NW'(g)) &&
                      ((pos_r[g] > PW'(MAX_POS)) ||
                       (pos_r[g] == '0 && pat_r[g] > SYM_W'(255)));
  end

  logic [PW-1:0]    cur_p;
  logic [SYM_W-1:0] cur_pat;
  logic [PW:0]      tri_v, addr0, addr1;
  logic [7:0]       mask0, mask1;
  logic             is_zero, is_odd, two_bytes, last_sym;

  assign cur_p     = pos_r[idx];
  assign cur_pat   = pat_r[idx];
  assign tri_v     = {1'b0, cur_p} + {2'b0, cur_p[PW-1:1]};
  assign is_zero   = (cur_p == '0);
  assign is_odd    = cur_p[0];
  assign two_bytes = !is_zero;
  assign last_sym  = (NW'(idx) + NW'(1)) == n_r;

  assign addr0 = is_odd ? tri_v : (is_zero ? '0 : tri_v - (PW+1)'(1));
  assign addr1 = is_odd ? tri_v + (PW+1)'(1) : tri_v;
  assign mask0 = is_odd ? cur_pat[11:4] : (is_zero ? cur_pat[7:0] : {4'h0, cur_pat[11:8]});
  assign mask1 = is_odd ? {cur_pat[3:0], 4'h0} : cur_pat[7:0];

  assign mem_en     = (st == S_RD) || (st == S_WR);
  assign mem_we     = (st == S_WR);
  assign mem_addr   = AW'(half ? addr1 : addr0);
  assign mem_wdata  = mem_rdata ^ (half ? mask1 : mask0);
  assign busy       = (st != S_IDLE);
  assign done       = done_q;
  assign corr_count = corr_q;
  assign fail_count = fail_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      gate_r <= 1'b0;
      half   <= 1'b0;
      done_q <= 1'b0;
      n_r    <= '0;
      idx    <= '0;
      corr_q <= '0;
      fail_q <= '0;
      for (int i = 0; i < MAX_ERR; i++) begin
        pos_r[i] <= '0;
        pat_r[i] <= '0;
      end
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          gate_r <= ecc_flag;
          n_r    <= (err_n > NW'(MAX_ERR)) ? NW'(MAX_ERR) : err_n;
          for (int i = 0; i < MAX_ERR; i++) begin
            pos_r[i] <= err_pos[i*PW +: PW];
            pat_r[i] <= err_pat[i*SYM_W +: SYM_W];
          end
          st <= S_CHK;
        end
        S_CHK: begin
          idx  <= '0;
          half <= 1'b0;
          if (!gate_r || n_r == '0) begin
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else if (|bad_v) begin
            fail_q <= fail_q + CNT_W'(1);
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else begin
            st <= S_RD;
          end
        end
        S_RD: st <= S_WR;
        S_WR: begin
          if (two_bytes && !half) begin
            half <= 1'b1;
            st   <= S_RD;
          end else if (last_sym) begin
            corr_q <= corr_q + CNT_W'(n_r);
            done_q <= 1'b1;
            half   <= 1'b0;
            st     <= S_IDLE;
          end else begin
            idx  <= idx + IW'(1);
            half <= 1'b0;
            st   <= S_RD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r9_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |-> ($past(mem_en && !mem_we) && mem_addr == $past(mem_addr)));

  a_r9_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we) |=> (mem_en && mem_we));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_fail_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_q != $past(fail_q)) |-> (done && fail_q == $past(fail_q) + CNT_W'(1) && corr_q == $past(corr_q)));

  a_r1_gate_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !gate_r) |-> (corr_q == $past(corr_q) && fail_q == $past(fail_q)));

  a_r2_no_access_bad: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> !(|bad_v));

  a_r7_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> ({1'b0, mem_addr} < (AW+1)'(DATA_BYTES + SPARE_BYTES)));

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(n_r));

endmodule

// File: tb/test_rs_symfix.sv
module test_rs_symfix;
  localparam int CLK_PERIOD = 10;
  localparam int BYTES  = 2112;
  localparam int MAXE   = 4;
  localparam int MAXPOS = 1374;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, ecc_flag = 1'b0;
  logic [2:0] err_n = '0;
  logic [47:0] err_pos = '0, err_pat = '0;
  logic busy, done, mem_en, mem_we;
  logic [11:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata = '0;
  logic [15:0] corr_count, fail_count;

  logic [7:0] bmem [BYTES];
  int rmem [BYTES];
  int sp [4];
  int sq [4];
  int total = 0, failc = 0, exp_corr = 0, exp_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rs_symfix i_rs_symfix (
    .clk(clk), .rst_n(rst_n), .start(start), .ecc_flag(ecc_flag), .err_n(err_n),
    .err_pos(err_pos), .err_pat(err_pat), .busy(busy), .done(done),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .corr_count(corr_count), .fail_count(fail_count));

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) bmem[mem_addr] <= mem_wdata;
      mem_rdata <= bmem[mem_addr];
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    total++;
    if (!ok) begin
      failc++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic set4(input int p0, input int q0, input int p1, input int q1,
                      input int p2, input int q2, input int p3, input int q3);
    sp[0] = p0; sq[0] = q0; sp[1] = p1; sq[1] = q1;
    sp[2] = p2; sq[2] = q2; sp[3] = p3; sq[3] = q3;
  endtask

  task automatic run_op(input bit g, input int n, input bit poke, input string tag);
    int neff, nb, mism;
    bit bad;
    int qa[$];
    int qm[$];
    neff = (n > MAXE) ? MAXE : n;
    bad = 0;
    for (int i = 0; i < neff; i++)
      if (sp[i] > MAXPOS || (sp[i] == 0 && sq[i] > 255)) bad = 1;
    if (g && !bad) begin
      for (int i = 0; i < neff; i++) begin
        int t;
        t = sp[i] + sp[i] / 2;
        if (sp[i] == 0) begin
          qa.push_back(0); qm.push_back(sq[i] & 255);
        end else if (sp[i] % 2 == 1) begin
          qa.push_back(t);     qm.push_back((sq[i] >> 4) & 255);
          qa.push_back(t + 1); qm.push_back((sq[i] & 15) << 4);
        end else begin
          qa.push_back(t - 1); qm.push_back((sq[i] >> 8) & 15);
          qa.push_back(t);     qm.push_back(sq[i] & 255);
        end
      end
    end
    nb = qa.size();
    @(negedge clk);
    ecc_flag = g;
    err_n = 3'(n);
    for (int i = 0; i < 4; i++) begin
      err_pos[i*12 +: 12] = 12'(sp[i]);
      err_pat[i*12 +: 12] = 12'(sq[i]);
    end
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(busy && !mem_en && !done, "R10", "check cycle busy/en/done", {busy, mem_en, done}, 3'b100);
    if (poke) begin
      start = 1'b1; err_n = 3'd1; ecc_flag = 1'b1;
      err_pos = '1; err_pat = '1;
    end
    for (int j = 1; j <= 2 * nb; j++) begin
      int a, m, e;
      bit wr;
      @(negedge clk);
      start = 1'b0;
      a = qa[(j - 1) / 2];
      m = qm[(j - 1) / 2];
      wr = (j % 2 == 0);
      chk(mem_en && (mem_we == wr) && int'(mem_addr) == a && !done && busy, tag,
          $sformatf("access %0d en/we/addr", j), {mem_en, mem_we, mem_addr}, {1'b1, wr, 12'(a)});
      if (wr) begin
        e = (rmem[a] ^ m) & 255;
        rmem[a] = e;
        chk(int'(mem_wdata) == e, tag, $sformatf("write data at %0d", a), mem_wdata, e);
      end
    end
    @(negedge clk);
    start = 1'b0;
    if (g) begin
      if (bad) exp_fail++;
      else exp_corr += neff;
    end
    chk(done && !mem_en && !busy, "R10", "done pulse due", {done, mem_en, busy}, 3'b100);
    chk(int'(corr_count) == exp_corr, tag, "corr_count", corr_count, exp_corr);
    chk(int'(fail_count) == exp_fail, tag, "fail_count", fail_count, exp_fail);
    @(negedge clk);
    chk(!done, "R10", "done one cycle only", done, 0);
    mism = 0;
    for (int i = 0; i < BYTES; i++) if (int'(bmem[i]) != rmem[i]) mism++;
    chk(mism == 0, tag, "buffer mismatches", mism, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      failc++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - failc, total);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < BYTES; i++) begin
      bmem[i] = 8'((i * 37 + 11) & 255);
      rmem[i] = (i * 37 + 11) & 255;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy && !done && !mem_en && corr_count == 0 && fail_count == 0, "R10", "reset state",
        {busy, done, mem_en}, 0);
    rst_n = 1'b1;

    set4(3, 12'h123, 2000, 12'hFFF, 0, 12'h3FF, 7, 1);
    run_op(0, 4, 0, "R1");
    set4(1, 12'hABC, 0, 0, 0, 0, 0, 0);
    run_op(1, 1, 0, "R4");
    set4(2, 12'h5E7, 0, 0, 0, 0, 0, 0);
    run_op(1, 1, 0, "R5");
    set4(0, 12'h05A, 0, 0, 0, 0, 0, 0);
    run_op(1, 1, 0, "R3");
    set4(0, 12'h100, 0, 0, 0, 0, 0, 0);
    run_op(1, 1, 0, "R3");
    set4(1365, 12'hC3A, 0, 0, 0, 0, 0, 0);
    run_op(1, 1, 0, "R6");
    set4(1366, 12'h9D2, 1373, 12'h4E1, 1374, 12'hFFF, 1367, 12'h81F);
    run_op(1, 4, 0, "R7");
    set4(10, 12'h111, 1375, 12'h222, 20, 12'h333, 0, 0);
    run_op(1, 3, 0, "R2");
    set4(5, 12'hF0F, 6, 12'h0F0, 1000, 12'hFFF, 0, 12'h1FF);
    run_op(1, 2, 0, "R8");
    set4(5, 12'hF0F, 6, 12'h0F0, 9, 12'h00F, 4, 12'hEEE);
    run_op(1, 4, 0, "R9");
    set4(11, 12'h777, 12, 12'h888, 13, 12'h999, 14, 12'hAAA);
    run_op(1, 7, 0, "R8");
    set4(0, 0, 0, 0, 0, 0, 0, 0);
    run_op(1, 0, 0, "R8");
    set4(100, 12'h345, 201, 12'h678, 0, 0, 0, 0);
    run_op(1, 2, 1, "R11");

    for (int k = 0; k < 40; k++) begin
      for (int i = 0; i < 4; i++) begin
        int r;
        r = $urandom_range(0, 19);
        sp[i] = (r == 0) ? 0 : (r == 1) ? $urandom_range(1375, 4095) : $urandom_range(1, MAXPOS);
        sq[i] = (sp[i] == 0 && $urandom_range(0, 1) == 1) ? $urandom_range(0, 255) : $urandom_range(0, 4095);
      end
      run_op($urandom_range(0, 7) != 0, $urandom_range(0, 5), 0, "R9");
    end

    finished = 1;
    $display("%0d/%0d checks passed", total - failc, total);
    $finish;
  end
endmodule